// File: doc/BRIEF.md
# Parallel Port Protocol Powerdown Control

This block decides when the two protocol engines of a parallel port, the enhanced-parallel (EPP) engine and the extended-capabilities (ECP) engine, may be switched off. It looks at three things: the automatic power management enable, the port's configured base mode, and the 3-bit mode field of the extended control register. The register matters only while the port is configured for ECP operation. The block produces one powerdown flag per engine.

The flags are not re-evaluated every cycle. They are recomputed and registered only when software writes the configuration or makes an accepted write to the extended control register. The block also holds that register's mode field and lets the host read it back.

Top module: `pp_mode_pwr_ctl`

## Requirements
- R1: While `auto_pm_en` is low, `epp_pd` and `ecp_pd` are both low in the same cycle. While it is high, they show the result of the last evaluation.
- R2: After a configuration write with `cfg_mode[0]` = 0 (EPP not enabled), `epp_pd` is high whenever automatic management is enabled.
- R3: After an evaluation with `cfg_mode[1]` = 1 (ECP mode) and a stored mode field other than 3'b100 (EPP), `epp_pd` is high. With the field at 3'b100 and EPP enabled, it is low.
- R4: After a configuration write with `cfg_mode[1]` = 0 (ECP not enabled), `ecp_pd` is high.
- R5: In ECP mode, `ecp_pd` is high for the mode field values 3'b000 (standard), 3'b001 (PS/2) and 3'b100 (EPP). It is low for 3'b010 (parallel FIFO), 3'b011 (ECP FIFO), 3'b101, 3'b110 (test) and 3'b111 (configuration).
- R6: The flags change only in the cycle after a configuration write (`cfg_wr`) or an accepted register write. A change on `cfg_mode` without `cfg_wr` has no effect.
- R7: A register write (`ecr_wr`) is accepted only while `cfg_mode[1]` is 1. The field is stored from `ecr_wdata[7:5]`. `ecr_rdata` returns the field in bits 7:5 and zero in bits 4:0.
- R8: After reset, both flags are low and the stored mode field is 3'b000.
- R9: When a configuration write and a register write fall in the same cycle, acceptance is judged on the `cfg_mode` value presented in that cycle. The evaluation then uses both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_pm_en | input | 1 | Automatic power management enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Base mode: bit 0 EPP enabled, bit 1 ECP mode |
| ecr_wr | input | 1 | Extended control register write strobe |
| ecr_wdata | input | 8 | Register write data, mode in bits 7:5 |
| ecr_rdata | output | 8 | Register read data |
| epp_pd | output | 1 | EPP engine powerdown |
| ecp_pd | output | 1 | ECP engine powerdown |

## Verification
A configuration write and a register write can land in the same cycle. In that case register acceptance depends on the configuration value being written at the same moment.

The bench provokes this both ways:
- It moves the base mode into ECP while writing the EPP code. The write must then be accepted, and the flags must reflect both new values.
- It moves the base mode out of ECP while writing a new code. The write must then be dropped, which the bench judges from the read-back field and both flags.

// File: rtl/pp_mode_pwr_ctl.sv
module pp_mode_pwr_ctl #(
  parameter int MW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_pm_en,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode,
  input  logic          ecr_wr,
  input  logic [DW-1:0] ecr_wdata,
  output logic [DW-1:0] ecr_rdata,
  output logic          epp_pd,
  output logic          ecp_pd
);
  localparam int MLO = DW - MW;
  localparam logic [MW-1:0] M_STD  = 3'b000;
  localparam logic [MW-1:0] M_PS2  = 3'b001;
  localparam logic [MW-1:0] M_EPP  = 3'b100;

  logic [MW-1:0] mode_q, mode_n;
  logic          wr_ok, eval;
  logic          epp_raw_q, ecp_raw_q, epp_nx, ecp_nx;

  assign wr_ok  = ecr_wr & cfg_mode[1];
  assign mode_n = wr_ok ? ecr_wdata[DW-1:MLO] : mode_q;
  assign eval   = cfg_wr | wr_ok;

  always_comb begin
    epp_nx = ~cfg_mode[0] | (cfg_mode[1] & (mode_n != M_EPP));
    ecp_nx = ~cfg_mode[1] |
             (mode_n == M_STD) | (mode_n == M_PS2) | (mode_n == M_EPP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      epp_raw_q <= 1'b0;
      ecp_raw_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      if (eval) begin
        epp_raw_q <= epp_nx;
        ecp_raw_q <= ecp_nx;
      end
    end
  end

  assign ecr_rdata = {mode_q, {MLO{1'b0}}};
  assign epp_pd    = auto_pm_en & epp_raw_q;
  assign ecp_pd    = auto_pm_en & ecp_raw_q;
endmodule

// File: rtl/pp_mode_pwr_ctl_chk.sv
module pp_mode_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_pm_en,
  input logic       cfg_wr,
  input logic [1:0] cfg_mode,
  input logic       ecr_wr,
  input logic [7:0] ecr_rdata,
  input logic       epp_pd,
  input logic       ecp_pd
);
  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_pm_en |-> (!epp_pd && !ecp_pd));

  // R6
  epp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !ecr_wr) |=> ($stable(epp_pd) || !$stable(auto_pm_en)));

  // R6
  ecp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !ecr_wr) |=> ($stable(ecp_pd) || !$stable(auto_pm_en)));

  // R7
  ecr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode[1] |=> $stable(ecr_rdata));

  // R2
  epp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_mode[0]) |=> (!auto_pm_en || epp_pd));

  // R4
  ecp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_mode[1]) |=> (!auto_pm_en || ecp_pd));

  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_rdata[4:0] == 5'd0);
endmodule

bind pp_mode_pwr_ctl pp_mode_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_pm_en(auto_pm_en), .cfg_wr(cfg_wr),
  .cfg_mode(cfg_mode), .ecr_wr(ecr_wr), .ecr_rdata(ecr_rdata),
  .epp_pd(epp_pd), .ecp_pd(ecp_pd)
);

// File: tb/pp_mode_pwr_ctl_bench.sv
`timescale 1ns/1ps
module pp_mode_pwr_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_pm_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       ecr_wr = 1'b0;
  logic [7:0] ecr_wdata = 8'h00;
  logic [7:0] ecr_rdata;
  logic       epp_pd, ecp_pd;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pp_mode_pwr_ctl u_pp_mode_pwr_ctl (
    .clk(clk), .rst_n(rst_n), .auto_pm_en(auto_pm_en), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .ecr_wr(ecr_wr), .ecr_wdata(ecr_wdata),
    .ecr_rdata(ecr_rdata), .epp_pd(epp_pd), .ecp_pd(ecp_pd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_epp(input logic [1:0] c, input logic [2:0] m);
    return !c[0] || (c[1] && m != 3'b100);
  endfunction

  function automatic bit exp_ecp(input logic [1:0] c, input logic [2:0] m);
    return !c[1] || m == 3'b000 || m == 3'b001 || m == 3'b100;
  endfunction

  task automatic wr(input bit cw, input logic [1:0] cv, input bit ew, input logic [2:0] ev);
    @(negedge clk);
    cfg_wr = cw; if (cw) cfg_mode = cv;
    ecr_wr = ew; ecr_wdata = {ev, 5'b10101};
    @(negedge clk);
    cfg_wr = 1'b0; ecr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 epp_pd after reset", epp_pd, 0);
    chk("R8 ecp_pd after reset", ecp_pd, 0);
    chk("R8 mode after reset", ecr_rdata, 8'h00);
  endtask

  task automatic t_cfg_sweep;
    auto_pm_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr(1'b1, 2'(c), 1'b0, 3'd0);
      chk("R2 epp_pd cfg sweep", epp_pd, exp_epp(2'(c), 3'd0));
      chk("R4 ecp_pd cfg sweep", ecp_pd, exp_ecp(2'(c), 3'd0));
    end
  endtask

  task automatic t_ecr_sweep;
    wr(1'b1, 2'b10, 1'b0, 3'd0);
    for (int m = 0; m < 8; m++) begin
      wr(1'b0, 2'b10, 1'b1, 3'(m));
      chk("R7 readback", ecr_rdata, m << 5);
      chk("R2 epp_pd ecp-only", epp_pd, 1);
      chk("R5 ecp_pd per mode", ecp_pd, exp_ecp(2'b10, 3'(m)));
    end
    wr(1'b1, 2'b11, 1'b0, 3'd0);
    for (int m = 0; m < 8; m++) begin
      wr(1'b0, 2'b11, 1'b1, 3'(m));
      chk("R3 epp_pd per mode", epp_pd, (m != 4) ? 1 : 0);
      chk("R5 ecp_pd with epp", ecp_pd, exp_ecp(2'b11, 3'(m)));
    end
  endtask

  task automatic t_enable;
    wr(1'b1, 2'b00, 1'b0, 3'd0);
    @(negedge clk); auto_pm_en = 1'b0; #1;
    chk("R1 epp_pd gated", epp_pd, 0);
    chk("R1 ecp_pd gated", ecp_pd, 0);
    @(negedge clk); auto_pm_en = 1'b1; #1;
    chk("R1 epp_pd restored", epp_pd, 1);
    chk("R1 ecp_pd restored", ecp_pd, 1);
  endtask

  task automatic t_reject;
    wr(1'b1, 2'b10, 1'b1, 3'b011);
    wr(1'b1, 2'b01, 1'b0, 3'd0);
    wr(1'b0, 2'b01, 1'b1, 3'b100);
    chk("R7 rejected write", ecr_rdata, 8'h60);
    chk("R7 flags epp unchanged", epp_pd, 0);
    chk("R7 flags ecp unchanged", ecp_pd, 1);
  endtask

  task automatic t_stable;
    wr(1'b1, 2'b11, 1'b1, 3'b100);
    chk("R6 epp baseline", epp_pd, 0);
    @(negedge clk); cfg_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R6 epp no cfg_wr", epp_pd, 0);
    chk("R6 ecp no cfg_wr", ecp_pd, 1);
  endtask

  task automatic t_same_cycle;
    wr(1'b1, 2'b01, 1'b0, 3'd0);
    wr(1'b1, 2'b11, 1'b1, 3'b100);
    chk("R9 accepted with new cfg", ecr_rdata, 8'h80);
    chk("R9 epp_pd both new", epp_pd, 0);
    chk("R9 ecp_pd both new", ecp_pd, 1);
    wr(1'b1, 2'b01, 1'b1, 3'b011);
    chk("R9 rejected with new cfg", ecr_rdata, 8'h80);
    chk("R9 epp_pd after leave", epp_pd, 0);
    chk("R9 ecp_pd after leave", ecp_pd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_sweep();
    t_ecr_sweep();
    t_enable();
    t_reject();
    t_stable();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule